// File: doc/BRIEF.md
# Receive Frame Status Trailer Appender

This block sits on the receive path of a fast infrared link, between the deframer that delivers payload bytes and the receive FIFO that a DMA engine empties into a ring buffer in host memory. While a frame is open it passes each payload byte into the FIFO and counts it. It also notes three conditions: an abort strobe, a frame-error strobe, and any payload byte lost because the FIFO had no room.

How a frame closes depends on `dma_en`, which is sampled on the end strobe. With DMA on, the block appends two status bytes to the FIFO. The first holds the low part of the 13-bit byte count. The second holds the three condition flags above the upper count bits. Once that second byte is written, the frame pointer is set to the ring address it landed on, so the host can find the trailer of the newest frame. With DMA off, nothing is appended. A sticky end-of-frame flag is set instead. The sticky status flags stay set until the host pulses `stat_rd`, and frames may follow one another with no gap.

Top module: `rx_trailer_appender`

## Requirements
- R1: After a synchronous reset the block is idle. `fifo_wr` is 0, `frame_ptr` is 0 and all four status flags are 0.
- R2: While a frame is open, a byte presented with `in_valid` and `fifo_ready` high appears on `fifo_wdata` with `fifo_wr` high in the same cycle. Bytes presented while no frame is open are never written.
- R3: The byte count clears on `in_sof`, also when `in_sof` arrives in the middle of a frame. It counts only the bytes written and saturates at 8191 without wrapping.
- R4: With DMA on, the first write after the end strobe is count bits 7..0. The next write is {abort in bit 7, frame error in bit 6, overrun in bit 5, count bits 12..8 in bits 4..0}. Each is written in the first cycle in which `fifo_ready` is high.
- R5: While `fifo_ready` is low, a pending trailer byte is held and not written. It goes out unchanged once room returns.
- R6: A payload byte presented while `fifo_ready` is low is dropped and sets the frame's overrun flag.
- R7: A write counter advances by one, modulo RING_DEPTH, on every FIFO write. On the cycle after the second trailer byte is written, `frame_ptr` takes the address that byte was written to. It does not change at any other time.
- R8: With DMA off, the end strobe causes no trailer write, and `stat_eof` becomes 1 on the following cycle.
- R9: At every frame end, in both modes, the frame's abort, frame-error and overrun flags are OR-ed into the sticky flags `stat_abort`, `stat_ferr` and `stat_ovr`. A `stat_rd` pulse clears all four sticky flags. A flag being set in the same cycle wins over the clear.
- R10: While a trailer is pending, `in_valid`, `in_sof`, `in_eof`, `in_abort` and `in_ferr` have no effect.
- R11: A start strobe in the cycle right after the second trailer byte is written opens the next frame with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte present |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | Frame start strobe |
| in_eof | input | 1 | Frame end strobe |
| in_abort | input | 1 | Abort condition strobe |
| in_ferr | input | 1 | Frame error strobe |
| dma_en | input | 1 | Selects trailer mode at frame end |
| fifo_ready | input | 1 | Receive FIFO can accept a byte |
| stat_rd | input | 1 | Host status read, clears sticky flags |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |
| frame_ptr | output | ADDR_W | Ring address of the newest second trailer byte |
| stat_eof | output | 1 | Sticky end of frame (DMA off) |
| stat_abort | output | 1 | Sticky abort |
| stat_ferr | output | 1 | Sticky frame error |
| stat_ovr | output | 1 | Sticky overrun |

## Verification
Bad internal state shows up at the ports in one of four ways, and the bench catches each on the cycle it happens.

- A wrong count or wrong frame flag appears in one of the two trailer bytes, on the cycle that byte is written.
- A wrong sequencer state shows up as a stray or missing `fifo_wr`, or as a trailer that is late or early, in the same cycle.
- A wrong write counter shows up as a bad `frame_ptr` on the cycle after the next trailer.
- A bad sticky flag is visible on the cycle after the frame end.

A behavioural model in the bench predicts every output on every clock, so no mismatch survives more than one cycle past the edge that caused it.

// File: rtl/rxtr_pkg.sv
package rxtr_pkg;

    localparam int CNT_W = 13;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_TRL_LO,
        ST_TRL_HI
    } rx_state_e;

    typedef struct packed {
        logic             abort;
        logic             ferr;
        logic             ovr;
        logic [CNT_W-1:0] cnt;
    } frame_stat_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    function automatic logic [7:0] trl_hi_byte(input frame_stat_t f);
        return {f.abort, f.ferr, f.ovr, f.cnt[CNT_W-1:8]};
    endfunction

endpackage

// File: rtl/rxtr_frame_track.sv
module rxtr_frame_track
    import rxtr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        byte_ok,
    input  logic        byte_drop,
    input  logic        abort_stb,
    input  logic        ferr_stb,
    output frame_stat_t fs_q,
    output frame_stat_t fs_d
);

    always_comb begin
        fs_d = fs_q;
        if (clr) begin
            fs_d = '0;
        end else begin
            if (byte_ok)   fs_d.cnt   = sat_inc(fs_q.cnt);
            if (byte_drop) fs_d.ovr   = 1'b1;
            if (abort_stb) fs_d.abort = 1'b1;
            if (ferr_stb)  fs_d.ferr  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fs_q <= '0;
        else     fs_q <= fs_d;
    end

    // R3
    cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && fs_q.cnt == CNT_MAX) |=> (fs_q.cnt == CNT_MAX));

endmodule

// File: rtl/rxtr_seq.sv
module rxtr_seq
    import rxtr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_abort,
    input  logic        in_ferr,
    input  logic        dma_en,
    input  logic        fifo_ready,
    input  frame_stat_t fs_q,
    output logic        fifo_wr,
    output logic [7:0]  fifo_wdata,
    output logic        trk_clr,
    output logic        trk_ok,
    output logic        trk_drop,
    output logic        trk_abort,
    output logic        trk_ferr,
    output logic        end_nodma,
    output logic        trl_hi_wr
);

    rx_state_e state, state_d;
    logic      open_q, in_rx, end_evt;

    assign open_q    = (state == ST_IDLE) || (state == ST_RX);
    assign trk_clr   = open_q && in_sof;
    assign in_rx     = (state == ST_RX) && !in_sof;
    assign trk_ok    = in_rx && in_valid && fifo_ready;
    assign trk_drop  = in_rx && in_valid && !fifo_ready;
    assign trk_abort = in_rx && in_abort;
    assign trk_ferr  = in_rx && in_ferr;
    assign end_evt   = in_rx && in_eof;
    assign end_nodma = end_evt && !dma_en;
    assign trl_hi_wr = (state == ST_TRL_HI) && fifo_ready;

    always_comb begin
        fifo_wr    = 1'b0;
        fifo_wdata = '0;
        state_d    = state;
        unique case (state)
            ST_IDLE: begin
                if (in_sof) state_d = ST_RX;
            end
            ST_RX: begin
                fifo_wr    = trk_ok;
                fifo_wdata = in_data;
                if (end_evt) state_d = dma_en ? ST_TRL_LO : ST_IDLE;
            end
            ST_TRL_LO: begin
                fifo_wr    = fifo_ready;
                fifo_wdata = fs_q.cnt[7:0];
                if (fifo_ready) state_d = ST_TRL_HI;
            end
            ST_TRL_HI: begin
                fifo_wr    = fifo_ready;
                fifo_wdata = trl_hi_byte(fs_q);
                if (fifo_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    // R5
    wr_needs_room_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> fifo_ready);

    // R5
    trl_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRL_LO && !fifo_ready) |=> (state == ST_TRL_LO));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !fifo_wr);

endmodule

// File: rtl/rx_trailer_appender.sv
module rx_trailer_appender
    import rxtr_pkg::*;
#(
    parameter int RING_DEPTH = 64,
    localparam int ADDR_W = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_abort,
    input  logic              in_ferr,
    input  logic              dma_en,
    input  logic              fifo_ready,
    input  logic              stat_rd,
    output logic              fifo_wr,
    output logic [7:0]        fifo_wdata,
    output logic [ADDR_W-1:0] frame_ptr,
    output logic              stat_eof,
    output logic              stat_abort,
    output logic              stat_ferr,
    output logic              stat_ovr
);

    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(RING_DEPTH - 1);

    frame_stat_t       fs_q, fs_d;
    logic              trk_clr, trk_ok, trk_drop, trk_abort, trk_ferr;
    logic              end_nodma, trl_hi_wr, set_err;
    logic [ADDR_W-1:0] waddr;

    rxtr_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_abort   (in_abort),
        .in_ferr    (in_ferr),
        .dma_en     (dma_en),
        .fifo_ready (fifo_ready),
        .fs_q       (fs_q),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .trk_clr    (trk_clr),
        .trk_ok     (trk_ok),
        .trk_drop   (trk_drop),
        .trk_abort  (trk_abort),
        .trk_ferr   (trk_ferr),
        .end_nodma  (end_nodma),
        .trl_hi_wr  (trl_hi_wr)
    );

    rxtr_frame_track u_track (
        .clk       (clk),
        .rst       (rst),
        .clr       (trk_clr),
        .byte_ok   (trk_ok),
        .byte_drop (trk_drop),
        .abort_stb (trk_abort),
        .ferr_stb  (trk_ferr),
        .fs_q      (fs_q),
        .fs_d      (fs_d)
    );

    assign set_err = end_nodma || trl_hi_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr      <= '0;
            frame_ptr  <= '0;
            stat_eof   <= 1'b0;
            stat_abort <= 1'b0;
            stat_ferr  <= 1'b0;
            stat_ovr   <= 1'b0;
        end else begin
            if (fifo_wr)   waddr     <= (waddr == ADDR_LAST) ? '0 : waddr + 1'b1;
            if (trl_hi_wr) frame_ptr <= waddr;
            stat_eof   <= (stat_eof   && !stat_rd) || end_nodma;
            stat_abort <= (stat_abort && !stat_rd) || (set_err && fs_d.abort);
            stat_ferr  <= (stat_ferr  && !stat_rd) || (set_err && fs_d.ferr);
            stat_ovr   <= (stat_ovr   && !stat_rd) || (set_err && fs_d.ovr);
        end
    end

    // R7
    ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_ptr) |-> $past(trl_hi_wr));

    // R8
    eof_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_eof) |-> $past(end_nodma));

endmodule

// File: tb/tb_rx_trailer_appender.sv
module tb_rx_trailer_appender;

    localparam int CLK_P = 10;
    localparam int RING  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 0, in_sof = 0, in_eof = 0, in_abort = 0, in_ferr = 0;
    logic [7:0] in_data = 0;
    logic       dma_en = 0, fifo_ready = 1, stat_rd = 0;
    logic       fifo_wr;
    logic [7:0] fifo_wdata;
    logic [5:0] frame_ptr;
    logic       stat_eof, stat_abort, stat_ferr, stat_ovr;

    rx_trailer_appender #(.RING_DEPTH(RING)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort), .in_ferr(in_ferr),
        .dma_en(dma_en), .fifo_ready(fifo_ready), .stat_rd(stat_rd),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .frame_ptr(frame_ptr),
        .stat_eof(stat_eof), .stat_abort(stat_abort), .stat_ferr(stat_ferr),
        .stat_ovr(stat_ovr)
    );

    always #(CLK_P/2) clk = ~clk;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    done = 0;
    string ph = "R1";

    // reference model state: 0 idle, 1 frame open, 2 low trailer, 3 high trailer
    int m_st = 0, m_cnt = 0, m_ab = 0, m_fe = 0, m_ov = 0, m_wa = 0, m_ptr = 0;
    int s_eof = 0, s_ab = 0, s_fe = 0, s_ov = 0;
    int last_lo = -1, last_hi = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_wr();
        if (m_st == 1) return (in_valid && fifo_ready && !in_sof) ? 1 : 0;
        if (m_st == 2 || m_st == 3) return fifo_ready ? 1 : 0;
        return 0;
    endfunction

    function automatic int exp_data();
        if (m_st == 1) return int'(in_data);
        if (m_st == 2) return m_cnt % 256;
        return (m_ab << 7) | (m_fe << 6) | (m_ov << 5) | (m_cnt / 256);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_ab = 0; m_fe = 0; m_ov = 0; m_wa = 0; m_ptr = 0;
            s_eof = 0; s_ab = 0; s_fe = 0; s_ov = 0;
        end else begin
            int w, wa_old;
            w = exp_wr();
            wa_old = m_wa;
            if (w != 0) m_wa = (m_wa + 1) % RING;
            if (stat_rd) begin s_eof = 0; s_ab = 0; s_fe = 0; s_ov = 0; end
            if ((m_st == 0 || m_st == 1) && in_sof) begin
                m_st = 1; m_cnt = 0; m_ab = 0; m_fe = 0; m_ov = 0;
            end else if (m_st == 1) begin
                if (in_valid) begin
                    if (fifo_ready) m_cnt = (m_cnt < 8191) ? m_cnt + 1 : 8191;
                    else m_ov = 1;
                end
                if (in_abort) m_ab = 1;
                if (in_ferr) m_fe = 1;
                if (in_eof) begin
                    if (dma_en) m_st = 2;
                    else begin
                        m_st = 0; s_eof = 1;
                        s_ab |= m_ab; s_fe |= m_fe; s_ov |= m_ov;
                    end
                end
            end else if (m_st == 2) begin
                if (fifo_ready) m_st = 3;
            end else if (m_st == 3) begin
                if (fifo_ready) begin
                    m_ptr = wa_old; m_st = 0;
                    s_ab |= m_ab; s_fe |= m_fe; s_ov |= m_ov;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            int ew;
            ew = exp_wr();
            chk(int'(fifo_wr) == ew, {ph, " fifo_wr"}, int'(fifo_wr), ew);
            if (ew != 0) begin
                chk(int'(fifo_wdata) == exp_data(), (m_st == 1) ? "R2 data" : "R4 trailer",
                    int'(fifo_wdata), exp_data());
                if (m_st == 2) last_lo = int'(fifo_wdata);
                if (m_st == 3) last_hi = int'(fifo_wdata);
            end
            chk(int'(frame_ptr) == m_ptr, "R7 frame_ptr", int'(frame_ptr), m_ptr);
            chk(int'(stat_eof) == s_eof, "R8 stat_eof", int'(stat_eof), s_eof);
            chk(int'(stat_abort) == s_ab, "R9 stat_abort", int'(stat_abort), s_ab);
            chk(int'(stat_ferr) == s_fe, "R9 stat_ferr", int'(stat_ferr), s_fe);
            chk(int'(stat_ovr) == s_ov, "R6 stat_ovr", int'(stat_ovr), s_ov);
        end
    end

    task automatic step(input bit v, input logic [7:0] d, input bit sof, input bit eof,
                        input bit ab, input bit fe, input bit rdy, input bit rd);
        @(negedge clk);
        in_valid = v; in_data = d; in_sof = sof; in_eof = eof;
        in_abort = ab; in_ferr = fe; fifo_ready = rdy; stat_rd = rd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic send(input int n, input int seed);
        for (int i = 0; i < n; i++) step(1, 8'((seed + i * 7) & 255), 0, 0, 0, 0, 1, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        // R1 reset state
        chk(fifo_wr == 0, "R1 fifo_wr", int'(fifo_wr), 0);
        chk(frame_ptr == 0, "R1 frame_ptr", int'(frame_ptr), 0);
        chk({stat_eof, stat_abort, stat_ferr, stat_ovr} == 0, "R1 status",
            int'({stat_eof, stat_abort, stat_ferr, stat_ovr}), 0);

        // R2: bytes outside a frame are ignored
        ph = "R2";
        send(3, 5);
        // R4: DMA frame with trailer, R7 pointer update
        ph = "R4"; dma_en = 1;
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(5, 11);
        step(0, 0, 0, 1, 0, 0, 1, 0);
        drain();
        chk(last_lo == 5, "R4 low trailer byte", last_lo, 5);
        chk(last_hi == 0, "R4 high trailer byte", last_hi, 0);

        // R8: non-DMA frame with frame error, then R9 clear
        ph = "R8"; dma_en = 0;
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(3, 40);
        step(0, 0, 0, 1, 0, 1, 1, 0);
        idle(2);
        ph = "R9";
        step(0, 0, 0, 0, 0, 0, 1, 1);
        idle(2);

        // R5: trailer stalls, abort flag
        ph = "R5"; dma_en = 1;
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(4, 90);
        step(0, 0, 0, 1, 1, 0, 1, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
        drain();

        // R6: dropped payload bytes set overrun
        ph = "R6";
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(2, 3);
        step(1, 8'h55, 0, 0, 0, 0, 0, 0);
        step(1, 8'h66, 0, 0, 0, 0, 0, 0);
        send(2, 9);
        step(0, 0, 0, 1, 0, 0, 1, 0);
        drain();
        chk(last_hi == 8'h20 + 0, "R6 overrun in trailer", last_hi, 8'h20);

        // R10: inputs during pending trailer ignored
        ph = "R10";
        step(0, 0, 0, 0, 0, 0, 1, 1);
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(6, 77);
        step(0, 0, 0, 1, 0, 0, 1, 0);
        step(1, 8'hAA, 1, 1, 1, 1, 0, 0);
        step(1, 8'hBB, 0, 1, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        step(1, 8'hCC, 1, 1, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        idle(2);
        chk(last_lo == 6, "R10 count unaffected", last_lo, 6);
        chk(last_hi == 0, "R10 flags unaffected", last_hi, 0);

        // R11: back-to-back frames, sof right after trailer
        ph = "R11";
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(2, 1);
        step(0, 0, 0, 1, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(1, 2);
        step(0, 0, 0, 1, 0, 0, 1, 0);
        drain();
        chk(last_lo == 1, "R11 next frame count", last_lo, 1);

        // R3: restart mid frame, then saturation
        ph = "R3";
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(9, 4);
        step(1, 8'h12, 1, 0, 0, 0, 1, 0);
        send(3, 8);
        step(0, 0, 0, 1, 0, 0, 1, 0);
        drain();
        chk(last_lo == 3, "R3 restart clears count", last_lo, 3);
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(8200, 0);
        step(0, 0, 0, 1, 0, 0, 1, 0);
        drain();
        chk(last_lo == 255, "R3 saturated low byte", last_lo, 255);
        chk(last_hi == 31, "R3 saturated high byte", last_hi, 31);

        // R9: set wins over same-cycle clear
        ph = "R9"; dma_en = 0;
        step(0, 0, 1, 0, 0, 0, 1, 0);
        send(1, 3);
        step(0, 0, 0, 1, 1, 0, 1, 1);
        idle(2);
        chk(stat_eof == 1, "R9 set beats clear", int'(stat_eof), 1);
        step(0, 0, 0, 0, 0, 0, 1, 1);
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule